// File: doc/BRIEF.md
# Byte-Lane Page-Mode DRAM Controller

This block connects a 16-bit processor core to fast-page or extended-data-out DRAM that has only an 8-bit data path. The core issues either a single word write or a burst code fetch of one to eight words. The controller opens the row once, then runs one page-mode column cycle per byte while the row stays open. It multiplexes row and column onto a shared address bus, drives the active-low row strobe (which also acts as the chip select), the column strobe, output enable and write enable, and steers bytes on a bidirectional 8-bit bus.

A word always occupies two adjacent columns: the low byte at the even column and the high byte at the odd column. Fetched bytes are packed back into 16-bit words in little-endian order, and each completed word is handed to the core with a one-clock valid strobe. Read bytes are sampled one clock after their column strobe has gone low, which relies on the extended-data-out hold behaviour of the memory. After the last column cycle the row is closed and a precharge interval runs before the next request is taken. A request that arrives during a transfer waits until that interval is over.

Top module: `dram_byte_lane_ctrl`

Clock numbering used below: the rising edge that accepts a request is edge 0, and clock n is the period that starts at edge n-1.

## Requirements
- R1: After a request is accepted at edge 0, clock 1 puts the row address on `mem_addr` with `mem_ras_n` high, clock 2 holds the row address with `mem_ras_n` low, and `mem_ras_n` stays low through the clock after the last column cycle.
- R2: Byte k of a transfer uses clocks 3+2k and 4+2k: its column address appears in clock 3+2k with `mem_cas_n` high, and `mem_cas_n` is low only in clock 4+2k; the column strobe is never low while the row strobe is high, and the address is stable while it is low.
- R3: The request address is a byte address whose upper ROW_W bits are the row and lower COL_W bits the column; bit 0 is ignored, so the base column is even, and byte k goes to column (base + k) modulo 2^COL_W, wrapping inside the same row.
- R4: A word write makes exactly two column cycles whatever `req_len` holds: `req_wdata[7:0]` at the even column, then `req_wdata[15:8]` at the odd column; `mem_we_n` is low and the byte is driven on `mem_dq` in both clocks of each column cycle.
- R5: A burst fetch transfers 2*(`req_len`+1) bytes (2 to 16); `mem_oe_n` is low from clock 3 through the clock after the last column strobe, the controller leaves `mem_dq` undriven, and `mem_we_n` and `mem_oe_n` are never low together.
- R6: Byte k of a fetch is sampled at edge 5+2k, the edge that ends the clock following its column-strobe clock (edges 5, 7, 9, 11 for a four-byte fetch, that is the start of clocks 6, 8, 10, 12).
- R7: Fetched word j is {byte 2j+1, byte 2j} and appears on `rd_data` with `rd_valid` high for exactly clock 8+4j.
- R8: `mem_ras_n` goes high in the clock after the last column cycle's trailing clock and stays high for at least PRECHARGE clocks before it falls again; `req_ready` is low from clock 1 until the precharge has ended, and a request held waiting is accepted at the first edge where `req_ready` is high.
- R9: While reset is asserted all four strobes are high, `mem_dq` is undriven and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Controller can take a request at this edge |
| req_write | input | 1 | 1 = word write, 0 = burst fetch |
| req_addr | input | ROW_W+COL_W | Byte address {row, column}; bit 0 ignored |
| req_wdata | input | 16 | Word to write |
| req_len | input | $clog2(MAX_WORDS) | Fetch length in words minus one; ignored for writes |
| rd_valid | output | 1 | One-clock strobe per fetched word |
| rd_data | output | 16 | Fetched word, little-endian packed |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, also chip select |
| mem_cas_n | output | 1 | Column strobe for the single byte lane |
| mem_oe_n | output | 1 | Output enable |
| mem_we_n | output | 1 | Write enable |
| mem_dq | inout | 8 | Byte data bus |

## Verification
The main function is driven with a four-byte fetch, which pins the sampling edges and packing order, a one-word fetch, a sixteen-byte fetch whose columns cross the top of the row, and writes at odd and even addresses with a nonzero length field that must be ignored. Write-then-read pairs on the same columns tell apart swapped byte lanes and wrong column offsets, which a pin check alone could miss when both bytes match. Requests presented back to back, and others after idle gaps of different lengths, separate a correct hold-off through precharge from a controller that accepts early or stalls an extra clock.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_RASD = 3'd2,
    ST_COLH = 3'd3,
    ST_COLL = 3'd4,
    ST_TAIL = 3'd5,
    ST_PRE  = 3'd6
  } dbl_state_e;

  function automatic logic row_open(input dbl_state_e s);
    return (s == ST_RASD) || (s == ST_COLH) || (s == ST_COLL) || (s == ST_TAIL);
  endfunction

  function automatic logic col_phase(input dbl_state_e s);
    return (s == ST_COLH) || (s == ST_COLL);
  endfunction

endpackage

// File: rtl/dbl_seq.sv
module dbl_seq
  import dbl_pkg::*;
#(
  parameter int ROW_W     = 9,
  parameter int COL_W     = 9,
  parameter int LEN_W     = 3,
  parameter int PRECHARGE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [15:0]            req_wdata,
  input  logic [LEN_W-1:0]       req_len,
  output logic                   req_ready,
  output dbl_state_e             state,
  output logic [LEN_W:0]         idx,
  output logic                   is_write,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col_base,
  output logic [15:0]            wdata,
  output logic                   capture
);

  localparam int PRE_W = $clog2(PRECHARGE + 1);
  localparam int IDX_W = LEN_W + 1;

  dbl_state_e         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [PRE_W-1:0]   pre_q, pre_d;
  logic               load;
  logic               wr_q;
  logic [LEN_W-1:0]   len_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic [15:0]        wdata_q;
  logic               cap_q;
  logic [IDX_W-1:0]   last_idx;

  assign last_idx = {len_q, 1'b1};

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    pre_d   = pre_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_ROW;
          load    = 1'b1;
        end
      end
      ST_ROW:  state_d = ST_RASD;
      ST_RASD: begin
        state_d = ST_COLH;
        idx_d   = '0;
      end
      ST_COLH: state_d = ST_COLL;
      ST_COLL: begin
        if (idx_q == last_idx) begin
          state_d = ST_TAIL;
        end else begin
          state_d = ST_COLH;
          idx_d   = idx_q + 1'b1;
        end
      end
      ST_TAIL: begin
        state_d = ST_PRE;
        pre_d   = '0;
      end
      ST_PRE: begin
        if (pre_q == PRE_W'(PRECHARGE - 1)) state_d = ST_IDLE;
        else pre_d = pre_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pre_q   <= '0;
      cap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pre_q   <= pre_d;
      cap_q   <= (state_q == ST_COLL) && !wr_q;
    end
  end

  // request latch, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      len_q   <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (load) begin
      wr_q    <= req_write;
      len_q   <= req_write ? '0 : req_len;
      row_q   <= req_addr[ROW_W+COL_W-1:COL_W];
      col_q   <= {req_addr[COL_W-1:1], 1'b0};
      wdata_q <= req_wdata;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign state     = state_q;
  assign idx       = idx_q;
  assign is_write  = wr_q;
  assign row       = row_q;
  assign col_base  = col_q;
  assign wdata     = wdata_q;
  assign capture   = cap_q;

endmodule

// File: rtl/dbl_addr_mux.sv
module dbl_addr_mux
  import dbl_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int IDX_W = 4
) (
  input  dbl_state_e                             state,
  input  logic [ROW_W-1:0]                       row,
  input  logic [COL_W-1:0]                       col_base,
  input  logic [IDX_W-1:0]                       idx,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr
);

  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [COL_W-1:0] col_now;

  // column arithmetic wraps inside the open row
  assign col_now = col_base + COL_W'(idx);

  always_comb begin
    if ((state == ST_ROW) || (state == ST_RASD)) mem_addr = MA_W'(row);
    else                                         mem_addr = MA_W'(col_now);
  end

endmodule

// File: rtl/dbl_rd_pack.sv
module dbl_rd_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cap,
  input  logic [7:0]  dq_in,
  output logic        rd_valid,
  output logic [15:0] rd_data
);

  logic       half_q, half_d;
  logic [7:0] lo_q, lo_d;
  logic [15:0] word_q, word_d;
  logic       vld_q, vld_d;

  always_comb begin
    half_d = half_q;
    lo_d   = lo_q;
    word_d = word_q;
    vld_d  = 1'b0;
    if (start) begin
      half_d = 1'b0;
    end else if (cap) begin
      if (!half_q) begin
        lo_d   = dq_in;
        half_d = 1'b1;
      end else begin
        word_d = {dq_in, lo_q};
        vld_d  = 1'b1;
        half_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      lo_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      lo_q   <= lo_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = word_q;

endmodule

// File: rtl/dram_byte_lane_ctrl.sv
module dram_byte_lane_ctrl
  import dbl_pkg::*;
#(
  parameter int ROW_W     = 9,
  parameter int COL_W     = 9,
  parameter int MAX_WORDS = 8,
  parameter int PRECHARGE = 2
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         req_valid,
  output logic                                         req_ready,
  input  logic                                         req_write,
  input  logic [ROW_W+COL_W-1:0]                       req_addr,
  input  logic [15:0]                                  req_wdata,
  input  logic [$clog2(MAX_WORDS)-1:0]                 req_len,
  output logic                                         rd_valid,
  output logic [15:0]                                  rd_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
  output logic                                         mem_ras_n,
  output logic                                         mem_cas_n,
  output logic                                         mem_oe_n,
  output logic                                         mem_we_n,
  inout  wire  [7:0]                                   mem_dq
);

  localparam int LEN_W = $clog2(MAX_WORDS);
  localparam int IDX_W = LEN_W + 1;

  logic              rst_meta_q, rst_sync_q;
  dbl_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              is_write;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col_base;
  logic [15:0]       wdata;
  logic              capture;
  logic              drive_en;
  logic [7:0]        drive_byte;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dbl_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .PRECHARGE(PRECHARGE)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_q),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_len(req_len), .req_ready(req_ready),
    .state(state), .idx(idx), .is_write(is_write), .row(row),
    .col_base(col_base), .wdata(wdata), .capture(capture)
  );

  dbl_addr_mux #(
    .ROW_W(ROW_W), .COL_W(COL_W), .IDX_W(IDX_W)
  ) u_amux (
    .state(state), .row(row), .col_base(col_base), .idx(idx), .mem_addr(mem_addr)
  );

  dbl_rd_pack u_pack (
    .clk(clk), .rst_n(rst_sync_q),
    .start(state == ST_ROW), .cap(capture), .dq_in(mem_dq),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // strobe decode from sequencer state
  always_comb begin
    mem_ras_n  = !row_open(state);
    mem_cas_n  = (state != ST_COLL);
    mem_we_n   = !(is_write && col_phase(state));
    mem_oe_n   = !(!is_write && (col_phase(state) || (state == ST_TAIL)));
    drive_en   = is_write && col_phase(state);
    drive_byte = idx[0] ? wdata[15:8] : wdata[7:0];
  end

  assign mem_dq = drive_en ? drive_byte : 8'bzzzz_zzzz;

endmodule

// File: rtl/dbl_ctrl_chk.sv
module dbl_ctrl_chk #(
  parameter int ROW_W     = 9,
  parameter int COL_W     = 9,
  parameter int PRECHARGE = 2
) (
  input logic                                         clk,
  input logic                                         rst_n,
  input logic                                         ras_n,
  input logic                                         cas_n,
  input logic                                         oe_n,
  input logic                                         we_n,
  input logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
  input logic [7:0]                                   dq,
  input logic                                         req_ready
);

  localparam int CW = $clog2(PRECHARGE + 1) + 1;

  logic [CW-1:0] hi_cnt;

  // consecutive clocks with the row strobe high, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_cnt <= CW'(PRECHARGE);
    else if (!ras_n)                     hi_cnt <= '0;
    else if (hi_cnt < CW'(PRECHARGE))    hi_cnt <= hi_cnt + 1'b1;
  end

  assert_cas_in_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  assert_cas_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |=> cas_n);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> $stable(addr));

  assert_wdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !we_n) |-> $stable(dq));

  assert_we_oe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  assert_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= CW'(PRECHARGE)));

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && cas_n && oe_n && we_n));

endmodule

bind dram_byte_lane_ctrl dbl_ctrl_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .PRECHARGE(PRECHARGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(mem_ras_n), .cas_n(mem_cas_n),
  .oe_n(mem_oe_n), .we_n(mem_we_n), .addr(mem_addr), .dq(mem_dq),
  .req_ready(req_ready)
);

// File: tb/dram_byte_lane_ctrl_tb.sv
module dram_byte_lane_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 9;
  localparam int COL_W = 9;
  localparam int PRE   = 2;
  localparam int CSZ   = 1 << COL_W;
  localparam int NST   = 8;
  localparam int WD    = 5000;

  typedef struct {
    bit          ras_n, cas_n, we_n, oe_n;
    bit          ca;
    int          addr;
    bit          cd;
    logic [7:0]  dq;
    bit          vld;
    logic [15:0] rd;
  } cyc_t;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [2:0]  req_len;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [8:0]  mem_addr;
  logic        mem_ras_n, mem_cas_n, mem_oe_n, mem_we_n;
  wire  [7:0]  mem_dq;
  logic        drv_en;
  logic [7:0]  drv_val;

  int nchk, nfail;
  cyc_t expq[$];
  logic [7:0] bus_mem [int];
  logic [7:0] ref_mem [int];

  bit          st_wr   [NST];
  int          st_addr [NST];
  logic [15:0] st_wd   [NST];
  int          st_len  [NST];
  int          st_gap  [NST];

  assign mem_dq = drv_en ? drv_val : 8'bzzzz_zzzz;

  dram_byte_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 8));
  endfunction

  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : pat(a);
  endfunction

  function automatic logic [7:0] bus_rd(input int a);
    return bus_mem.exists(a) ? bus_mem[a] : pat(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // behavioural pin-level expectation for one accepted request
  task automatic plan(input bit wr, input int addr, input logic [15:0] wd, input int len);
    int row, base, nb, lastb, total, nw;
    row   = addr / CSZ;
    base  = (addr % CSZ) & ~1;
    nb    = wr ? 2 : 2 * (len + 1);
    nw    = nb / 2;
    lastb = nb - 1;
    total = 5 + 2 * lastb + PRE;
    for (int c = 1; c <= total; c++) begin
      cyc_t e;
      e.ras_n = 1; e.cas_n = 1; e.we_n = 1; e.oe_n = 1;
      e.ca = 0; e.addr = 0; e.cd = 0; e.dq = '0; e.vld = 0; e.rd = '0;
      if (c <= 2) begin
        e.ca = 1; e.addr = row; e.ras_n = (c == 1);
      end else if (c <= 4 + 2 * lastb) begin
        int k;
        k = (c - 3) / 2;
        e.ras_n = 0;
        e.ca = 1;
        e.addr = (base + k) % CSZ;
        e.cas_n = ((c - 3) % 2) == 0;
        if (wr) begin
          e.we_n = 0; e.cd = 1; e.dq = (k == 0) ? wd[7:0] : wd[15:8];
        end else begin
          e.oe_n = 0;
        end
      end else if (c == 5 + 2 * lastb) begin
        e.ras_n = 0; e.oe_n = wr;
      end
      if (!wr && c >= 8 && ((c - 8) % 4) == 0 && ((c - 8) / 4) < nw) begin
        int j;
        j = (c - 8) / 4;
        e.vld = 1;
        e.rd = {ref_rd(row * CSZ + (base + 2 * j + 1) % CSZ),
                ref_rd(row * CSZ + (base + 2 * j) % CSZ)};
      end
      expq.push_back(e);
    end
    if (wr) begin
      ref_mem[row * CSZ + base]     = wd[7:0];
      ref_mem[row * CSZ + base + 1] = wd[15:8];
    end
  endtask

  initial begin
    int cyc, si, gap, tail;
    bit just_acc, ras_prev, cas_prev;
    int row_l;
    cyc_t e;
    bit exp_ready;

    // stimulus: fetch 4 bytes; write at odd address with length ignored (R3, R4);
    // read it back held off (R8); 16-byte fetch crossing the row end (R3, R5);
    // write/read pairs with gaps
    st_wr[0] = 0; st_addr[0] = 3 * CSZ + 16;   st_wd[0] = 16'h0;    st_len[0] = 1; st_gap[0] = 4;
    st_wr[1] = 1; st_addr[1] = 5 * CSZ + 65;   st_wd[1] = 16'hA55A; st_len[1] = 5; st_gap[1] = 0;
    st_wr[2] = 0; st_addr[2] = 5 * CSZ + 64;   st_wd[2] = 16'h0;    st_len[2] = 0; st_gap[2] = 0;
    st_wr[3] = 0; st_addr[3] = 7 * CSZ + 508;  st_wd[3] = 16'h0;    st_len[3] = 7; st_gap[3] = 3;
    st_wr[4] = 1; st_addr[4] = 7 * CSZ + 2;    st_wd[4] = 16'h1234; st_len[4] = 0; st_gap[4] = 1;
    st_wr[5] = 0; st_addr[5] = 7 * CSZ + 0;    st_wd[5] = 16'h0;    st_len[5] = 3; st_gap[5] = 0;
    st_wr[6] = 1; st_addr[6] = 0;              st_wd[6] = 16'hFF00; st_len[6] = 7; st_gap[6] = 2;
    st_wr[7] = 0; st_addr[7] = 0;              st_wd[7] = 16'h0;    st_len[7] = 0; st_gap[7] = 0;

    nchk = 0; nfail = 0;
    clk = 0; rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0;
    req_wdata = '0; req_len = '0; drv_en = 0; drv_val = '0;

    // R9: reset state
    repeat (5) begin
      @(negedge clk);
      chk(mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n, "R9", "strobes in reset",
          {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 4'hF);
      chk(mem_dq === 8'bzzzz_zzzz, "R9", "bus released in reset", mem_dq, 0);
      chk(!rd_valid, "R9", "rd_valid in reset", rd_valid, 0);
    end
    rst_n = 1;

    cyc = 0; si = 0; gap = st_gap[0]; just_acc = 0; tail = 0;
    ras_prev = 1; cas_prev = 1; row_l = 0;

    while (tail < 6 && cyc < WD) begin
      @(negedge clk);
      cyc++;
      // 1. compare with reference
      if (expq.size() > 0) begin
        e = expq.pop_front();
        exp_ready = 0;
      end else begin
        e.ras_n = 1; e.cas_n = 1; e.we_n = 1; e.oe_n = 1;
        e.ca = 0; e.addr = 0; e.cd = 0; e.dq = '0; e.vld = 0; e.rd = '0;
        exp_ready = 1;
      end
      chk(mem_ras_n == e.ras_n, "R1", "ras_n", mem_ras_n, e.ras_n);
      chk(mem_cas_n == e.cas_n, "R2", "cas_n", mem_cas_n, e.cas_n);
      chk(mem_we_n == e.we_n, "R4", "we_n", mem_we_n, e.we_n);
      chk(mem_oe_n == e.oe_n, "R5", "oe_n", mem_oe_n, e.oe_n);
      chk(req_ready == exp_ready, "R8", "req_ready", req_ready, exp_ready);
      chk(rd_valid == e.vld, "R7", "rd_valid timing", rd_valid, e.vld);
      if (e.vld)
        chk(rd_data == e.rd, "R6 R7", "rd_data", rd_data, e.rd);
      if (e.ca)
        chk(int'(mem_addr) == e.addr, "R3", "mem_addr", mem_addr, e.addr);
      if (e.cd)
        chk(mem_dq === e.dq, "R4", "write byte", mem_dq, e.dq);
      else if (!drv_en)
        chk(mem_dq === 8'bzzzz_zzzz, "R5", "bus released", mem_dq, 0);

      // 2. memory model: data held until OE rises or next CAS fall
      if (ras_prev && !mem_ras_n) row_l = int'(mem_addr);
      if (cas_prev && !mem_cas_n && !mem_ras_n) begin
        int a;
        a = row_l * CSZ + (int'(mem_addr) % CSZ);
        if (!mem_we_n) begin
          bus_mem[a] = mem_dq;
        end else begin
          drv_val = bus_rd(a);
          drv_en  = 1;
        end
      end
      if (mem_oe_n) drv_en = 0;
      ras_prev = mem_ras_n;
      cas_prev = mem_cas_n;

      // 3. stimulus
      if (just_acc) begin
        req_valid = 0;
        just_acc = 0;
        si++;
        if (si < NST) gap = st_gap[si];
      end
      if (!req_valid && si < NST) begin
        if (gap > 0) gap--;
        else begin
          req_valid = 1;
          req_write = st_wr[si];
          req_addr  = 18'(st_addr[si]);
          req_wdata = st_wd[si];
          req_len   = 3'(st_len[si]);
        end
      end
      if (req_valid && req_ready) begin
        plan(req_write, int'(req_addr), req_wdata, int'(req_len));
        just_acc = 1;
      end
      if (si >= NST && expq.size() == 0 && !req_valid) tail++;
    end

    if (cyc >= WD) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule